// File: doc/BRIEF.md
# Hidden Configuration Window for an ATA Task-File Port

This block sits between a host I/O bus and the task-file registers of an ATA drive port. In its normal, locked state every host read and write is forwarded to the drive untouched. A short sequence of ordinary task-file accesses opens a configuration window. It is two back-to-back 16-bit reads at offset 1 followed by a write of 0x03 to offset 2. While the window is open, host accesses stop reaching the drive. The same offsets then reach a small set of timing and control registers.

The window holds two timing sets. Each set has one byte for read-cycle timing and one byte for write-cycle timing. An index bit in the miscellaneous register picks which set offsets 0 and 1 reach. The control register decides which set drives the timing of drive 1. The miscellaneous register also carries an address-setup field and a ready-delay field, and both drives share them. A strap register reports the host clock strap. Writing 0x83 to offset 2 closes the window. The timing values are presented on output ports for a PIO sequencer, which is not part of this block.

Top module: `cfg_gateway`

## Requirements
- R1: After synchronous reset the window is closed, host_rdata is zero, and all timing outputs, addr_setup and rdy_delay are zero.
- R2: While locked, drv_addr, drv_word and drv_wdata follow the host bus in the same cycle. drv_rd and drv_wr follow host_rd and host_wr in the same cycle. Read data from drv_rdata appears on host_rdata one cycle after the read strobe.
- R3: Two consecutive word reads (host_word=1) at offset 1, immediately followed by a write whose low byte is 0x03 at offset 2, open the window from the next cycle on.
- R4: Any other access placed inside the unlock sequence restarts it. Examples are a byte read, a read at another offset, or an early 0x03 write. The window stays closed.
- R5: While the window is open, drv_rd and drv_wr stay low for every host access.
- R6: While open, a read returns the configuration byte zero-extended, and the upper byte is always zero. Reads of offsets 2, 4 and 7 return zero.
- R7: While open, offset 5 reads the strap: bit 0 equals strap_clk25 (1 = 25 MHz host clock, 0 = 33 MHz), and all other bits are zero.
- R8: Bit 0 of the miscellaneous register (offset 6) selects timing set A (0) or B (1). Later reads and writes at offset 0 (read timing) and offset 1 (write timing) reach that set. Only the low data byte is stored.
- R9: Drive 0 timing outputs always come from set A. Drive 1 outputs come from set B when control (offset 3) bit 0 is 1, and from set A when it is 0. All timing outputs lag the registers by one cycle.
- R10: addr_setup shows miscellaneous bits 5:4, and rdy_delay shows bits 2:1.
- R11: While open, a write of low byte 0x83 to offset 2 closes the window from the next cycle. Any other write to offset 2 is ignored and the window stays open.
- R12: While locked, host writes change no configuration register.
- R13: The strap register is read-only, and writes to offset 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register offset from the port base |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe; takes priority over host_rd |
| host_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid the cycle after host_rd |
| strap_clk25 | input | 1 | Host clock strap (1 = 25 MHz) |
| drv_addr | output | 3 | Forwarded offset |
| drv_rd | output | 1 | Forwarded read strobe (locked only) |
| drv_wr | output | 1 | Forwarded write strobe (locked only) |
| drv_word | output | 1 | Forwarded access width |
| drv_wdata | output | 16 | Forwarded write data |
| drv_rdata | input | 16 | Read data from the drive registers |
| d0_rd_tim | output | 8 | Drive 0 read-cycle timing |
| d0_wr_tim | output | 8 | Drive 0 write-cycle timing |
| d1_rd_tim | output | 8 | Drive 1 read-cycle timing |
| d1_wr_tim | output | 8 | Drive 1 write-cycle timing |
| addr_setup | output | 2 | Shared address-setup field |
| rdy_delay | output | 2 | Shared ready-delay field |

## Verification
Some properties are checked on every cycle. No drive strobe is raised while the window is open. The window only opens right after a 0x03 write to offset 2, and it always closes after a 0x83 relock. Locked writes leave every timing output unchanged, and configuration reads carry a zero upper byte.

Other behaviour only shows through the bench's scenarios. This covers the exact unlock ordering and how it restarts after a broken sequence. It also covers which bank the index bit selects, the control mapping of drive 1 to set A or set B, and the values read back at each offset.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
  localparam int REG_W = 8;

  // register offsets (fixed: host software depends on them)
  localparam logic [2:0] OFS_RTIM  = 3'd0;
  localparam logic [2:0] OFS_WTIM  = 3'd1;
  localparam logic [2:0] OFS_KEY   = 3'd2;
  localparam logic [2:0] OFS_CTRL  = 3'd3;
  localparam logic [2:0] OFS_STRAP = 3'd5;
  localparam logic [2:0] OFS_MISC  = 3'd6;

  // offset read twice to arm the unlock sequence
  localparam logic [2:0] OFS_PROBE = 3'd1;

  localparam logic [REG_W-1:0] KEY_OPEN  = 8'h03;
  localparam logic [REG_W-1:0] KEY_CLOSE = 8'h83;

  typedef struct packed {
    logic [REG_W-1:0] rtim;
    logic [REG_W-1:0] wtim;
  } tim_set_t;
endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
  import cfg_gate_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int UNLOCK_READS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic              acc_word,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [REG_W-1:0]  acc_key,
  output logic              win_q
);
  localparam int CNT_W = $clog2(UNLOCK_READS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(UNLOCK_READS);

  logic [CNT_W-1:0] probe_cnt_q;
  logic             probe_hit;
  logic             key_slot;

  assign probe_hit = acc_rd && acc_word && (acc_addr == ADDR_W'(OFS_PROBE));
  assign key_slot  = acc_wr && (acc_addr == ADDR_W'(OFS_KEY));

  always_ff @(posedge clk) begin
    if (rst) begin
      probe_cnt_q <= '0;
      win_q       <= 1'b0;
    end else if (win_q) begin
      probe_cnt_q <= '0;
      if (key_slot && (acc_key == KEY_CLOSE)) win_q <= 1'b0;
    end else if (acc_wr) begin
      if (key_slot && (acc_key == KEY_OPEN) && (probe_cnt_q == CNT_FULL))
        win_q <= 1'b1;
      probe_cnt_q <= '0;
    end else if (acc_rd) begin
      if (!probe_hit)
        probe_cnt_q <= '0;
      else if (probe_cnt_q != CNT_FULL)
        probe_cnt_q <= probe_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_timing_bank.sv
module cfg_timing_bank
  import cfg_gate_pkg::*;
#(
  parameter int NUM_SETS = 2,
  localparam int SEL_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_rtim,
  input  logic             we_wtim,
  input  logic [SEL_W-1:0] sel,
  input  logic [REG_W-1:0] wdata,
  output tim_set_t         sets_q [NUM_SETS]
);
  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    always_ff @(posedge clk) begin
      if (rst) begin
        sets_q[g] <= '0;
      end else if (sel == IDX) begin
        if (we_rtim) sets_q[g].rtim <= wdata;
        if (we_wtim) sets_q[g].wtim <= wdata;
      end
    end
  end
endmodule

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs
  import cfg_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we_ctrl,
  input  logic             we_misc,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] misc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      misc_q <= '0;
    end else begin
      if (we_ctrl) ctrl_q <= wdata;
      if (we_misc) misc_q <= wdata;
    end
  end
endmodule

// File: rtl/cfg_gateway.sv
module cfg_gateway
  import cfg_gate_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = 16,
  parameter int NUM_SETS     = 2,
  parameter int UNLOCK_READS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_word,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              strap_clk25,
  output logic [ADDR_W-1:0] drv_addr,
  output logic              drv_rd,
  output logic              drv_wr,
  output logic              drv_word,
  output logic [DATA_W-1:0] drv_wdata,
  input  logic [DATA_W-1:0] drv_rdata,
  output logic [REG_W-1:0]  d0_rd_tim,
  output logic [REG_W-1:0]  d0_wr_tim,
  output logic [REG_W-1:0]  d1_rd_tim,
  output logic [REG_W-1:0]  d1_wr_tim,
  output logic [1:0]        addr_setup,
  output logic [1:0]        rdy_delay
);
  localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int PAD_W = DATA_W - REG_W;

  logic             win_q;
  logic             rd_acc;
  logic [REG_W-1:0] wbyte;
  logic             cfg_wr;
  logic             we_rtim, we_wtim, we_ctrl, we_misc;
  logic [SEL_W-1:0] set_sel;
  logic [SEL_W-1:0] d1_sel;
  logic [REG_W-1:0] ctrl_q, misc_q;
  logic [REG_W-1:0] cfg_byte;
  tim_set_t         sets_q [NUM_SETS];

  assign rd_acc = host_rd && !host_wr;
  assign wbyte  = host_wdata[REG_W-1:0];

  // pass-through path toward the drive
  assign drv_addr  = host_addr;
  assign drv_word  = host_word;
  assign drv_wdata = host_wdata;
  assign drv_rd    = rd_acc && !win_q;
  assign drv_wr    = host_wr && !win_q;

  cfg_unlock_fsm #(
    .ADDR_W      (ADDR_W),
    .UNLOCK_READS(UNLOCK_READS)
  ) unlock_i (
    .clk     (clk),
    .rst     (rst),
    .acc_rd  (rd_acc),
    .acc_wr  (host_wr),
    .acc_word(host_word),
    .acc_addr(host_addr),
    .acc_key (wbyte),
    .win_q   (win_q)
  );

  // configuration write decode
  assign cfg_wr  = host_wr && win_q;
  assign we_rtim = cfg_wr && (host_addr == ADDR_W'(OFS_RTIM));
  assign we_wtim = cfg_wr && (host_addr == ADDR_W'(OFS_WTIM));
  assign we_ctrl = cfg_wr && (host_addr == ADDR_W'(OFS_CTRL));
  assign we_misc = cfg_wr && (host_addr == ADDR_W'(OFS_MISC));
  assign set_sel = misc_q[SEL_W-1:0];

  cfg_timing_bank #(
    .NUM_SETS(NUM_SETS)
  ) bank_i (
    .clk    (clk),
    .rst    (rst),
    .we_rtim(we_rtim),
    .we_wtim(we_wtim),
    .sel    (set_sel),
    .wdata  (wbyte),
    .sets_q (sets_q)
  );

  cfg_ctrl_regs ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .we_ctrl(we_ctrl),
    .we_misc(we_misc),
    .wdata  (wbyte),
    .ctrl_q (ctrl_q),
    .misc_q (misc_q)
  );

  // configuration read select
  always_comb begin
    cfg_byte = '0;
    case (host_addr)
      ADDR_W'(OFS_RTIM):  cfg_byte = sets_q[set_sel].rtim;
      ADDR_W'(OFS_WTIM):  cfg_byte = sets_q[set_sel].wtim;
      ADDR_W'(OFS_CTRL):  cfg_byte = ctrl_q;
      ADDR_W'(OFS_STRAP): cfg_byte = {{(REG_W-1){1'b0}}, strap_clk25};
      ADDR_W'(OFS_MISC):  cfg_byte = misc_q;
      default:            cfg_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (rd_acc) begin
      host_rdata <= win_q ? {{PAD_W{1'b0}}, cfg_byte} : drv_rdata;
    end
  end

  // drive-to-set mapping: set B (index 1) for drive 1 when control bit 0 is set
  assign d1_sel = ctrl_q[0] ? SEL_W'(1) : SEL_W'(0);

  always_ff @(posedge clk) begin
    if (rst) begin
      d0_rd_tim  <= '0;
      d0_wr_tim  <= '0;
      d1_rd_tim  <= '0;
      d1_wr_tim  <= '0;
      addr_setup <= '0;
      rdy_delay  <= '0;
    end else begin
      d0_rd_tim  <= sets_q[0].rtim;
      d0_wr_tim  <= sets_q[0].wtim;
      d1_rd_tim  <= sets_q[d1_sel].rtim;
      d1_wr_tim  <= sets_q[d1_sel].wtim;
      addr_setup <= misc_q[5:4];
      rdy_delay  <= misc_q[2:1];
    end
  end
endmodule

// File: rtl/cfg_gateway_chk.sv
module cfg_gateway_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              win_i,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic [REG_W-1:0]  key_i,
  input logic [DATA_W-1:0] host_rdata,
  input logic              drv_rd,
  input logic              drv_wr,
  input logic [REG_W-1:0]  d0_rd_tim,
  input logic [REG_W-1:0]  d0_wr_tim,
  input logic [REG_W-1:0]  d1_rd_tim,
  input logic [REG_W-1:0]  d1_wr_tim,
  input logic [1:0]        addr_setup,
  input logic [1:0]        rdy_delay
);
  // R5: drive strobes quiet while configuration window is open
  p_no_drive_open_r5: assert property (@(posedge clk) disable iff (rst)
    win_i |-> (!drv_rd && !drv_wr));

  // R3: window only opens right after the opening key write
  p_open_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(win_i) |-> $past(host_wr && (host_addr == ADDR_W'(2)) && (key_i == 8'h03)));

  // R11: relock key closes the window
  p_relock_r11: assert property (@(posedge clk) disable iff (rst)
    (win_i && host_wr && (host_addr == ADDR_W'(2)) && (key_i == 8'h83)) |=> !win_i);

  // R12: locked writes leave every timing output unchanged
  p_locked_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!win_i && host_wr) |=> ($stable(d0_rd_tim) && $stable(d0_wr_tim) &&
                             $stable(d1_rd_tim) && $stable(d1_wr_tim) &&
                             $stable(addr_setup) && $stable(rdy_delay)));

  // R6: configuration reads carry a zero upper byte
  p_cfg_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (win_i && host_rd && !host_wr) |=> (host_rdata[DATA_W-1:REG_W] == '0));
endmodule

bind cfg_gateway cfg_gateway_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .REG_W (cfg_gate_pkg::REG_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .win_i     (win_q),
  .host_addr (host_addr),
  .host_rd   (host_rd),
  .host_wr   (host_wr),
  .key_i     (host_wdata[cfg_gate_pkg::REG_W-1:0]),
  .host_rdata(host_rdata),
  .drv_rd    (drv_rd),
  .drv_wr    (drv_wr),
  .d0_rd_tim (d0_rd_tim),
  .d0_wr_tim (d0_wr_tim),
  .d1_rd_tim (d1_rd_tim),
  .d1_wr_tim (d1_wr_tim),
  .addr_setup(addr_setup),
  .rdy_delay (rdy_delay)
);

// File: tb/cfg_gateway_tb_top.sv
module cfg_gateway_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 39;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0, host_word = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        strap_clk25 = 1'b1;
  logic [2:0]  drv_addr;
  logic        drv_rd, drv_wr, drv_word;
  logic [15:0] drv_wdata, drv_rdata;
  logic [7:0]  d0_rd_tim, d0_wr_tim, d1_rd_tim, d1_wr_tim;
  logic [1:0]  addr_setup, rdy_delay;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // drive model: register contents depend on the offset
  assign drv_rdata = 16'hA500 | {13'b0, drv_addr};

  cfg_gateway dut_i (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_word(host_word), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .strap_clk25(strap_clk25),
    .drv_addr(drv_addr), .drv_rd(drv_rd), .drv_wr(drv_wr), .drv_word(drv_word),
    .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
    .d0_rd_tim(d0_rd_tim), .d0_wr_tim(d0_wr_tim),
    .d1_rd_tim(d1_rd_tim), .d1_wr_tim(d1_wr_tim),
    .addr_setup(addr_setup), .rdy_delay(rdy_delay)
  );

  // vector: {is_wr, word, addr[2:0], req[3:0], data[15:0]}; reads compare data
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0,1'b1,3'd1,4'd2, 16'hA501},  // R2 locked read forwarded
    {1'b1,1'b0,3'd2,4'd4, 16'h0003},  // R4 key too early
    {1'b0,1'b1,3'd3,4'd4, 16'hA503},  // R4 still locked
    {1'b0,1'b1,3'd1,4'd4, 16'hA501},
    {1'b0,1'b1,3'd1,4'd4, 16'hA501},
    {1'b0,1'b0,3'd0,4'd4, 16'hA500},  // R4 byte read breaks sequence
    {1'b1,1'b0,3'd2,4'd4, 16'h0003},
    {1'b0,1'b1,3'd3,4'd4, 16'hA503},  // R4 still locked
    {1'b0,1'b1,3'd1,4'd3, 16'hA501},  // R3 proper sequence
    {1'b0,1'b1,3'd1,4'd3, 16'hA501},
    {1'b1,1'b0,3'd2,4'd3, 16'h0003},
    {1'b0,1'b1,3'd3,4'd3, 16'h0000},  // R3 control reads reset value
    {1'b0,1'b0,3'd5,4'd7, 16'h0001},  // R7 strap 25 MHz
    {1'b0,1'b1,3'd2,4'd6, 16'h0000},  // R6 unimplemented
    {1'b0,1'b1,3'd4,4'd6, 16'h0000},
    {1'b0,1'b1,3'd7,4'd6, 16'h0000},
    {1'b1,1'b0,3'd6,4'd8, 16'h0000},  // R8 select set A
    {1'b1,1'b1,3'd0,4'd8, 16'hFF21},
    {1'b1,1'b1,3'd1,4'd8, 16'h0032},
    {1'b1,1'b0,3'd6,4'd8, 16'h0001},  // R8 select set B
    {1'b1,1'b1,3'd0,4'd8, 16'h0043},
    {1'b1,1'b1,3'd1,4'd8, 16'h0054},
    {1'b0,1'b1,3'd0,4'd8, 16'h0043},
    {1'b0,1'b1,3'd1,4'd8, 16'h0054},
    {1'b1,1'b0,3'd6,4'd8, 16'h0000},
    {1'b0,1'b1,3'd0,4'd8, 16'h0021},  // R8 upper byte dropped
    {1'b0,1'b1,3'd1,4'd8, 16'h0032},
    {1'b1,1'b0,3'd3,4'd9, 16'h0085},  // R9 control
    {1'b0,1'b0,3'd3,4'd9, 16'h0085},
    {1'b1,1'b0,3'd6,4'd10,16'h0024},  // R10 setup 2, ready 2
    {1'b0,1'b0,3'd6,4'd10,16'h0024},
    {1'b1,1'b0,3'd5,4'd13,16'h00FE},  // R13 strap read-only
    {1'b0,1'b0,3'd5,4'd13,16'h0001},
    {1'b1,1'b0,3'd2,4'd11,16'h0055},  // R11 wrong key ignored
    {1'b0,1'b0,3'd3,4'd11,16'h0085},
    {1'b1,1'b0,3'd2,4'd11,16'h0083},  // R11 relock
    {1'b0,1'b1,3'd3,4'd11,16'hA503},
    {1'b1,1'b1,3'd0,4'd12,16'h0077},  // R12 locked write
    {1'b1,1'b0,3'd6,4'd12,16'h0031}   // R12 locked write
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc_start(input logic wr, input logic word, input logic [2:0] a,
                           input logic [15:0] d);
    @(negedge clk);
    host_wr    = wr;
    host_rd    = !wr;
    host_word  = word;
    host_addr  = a;
    host_wdata = wr ? d : 16'h0;
  endtask

  task automatic acc_end();
    @(negedge clk);
    host_wr = 1'b0;
    host_rd = 1'b0;
  endtask

  task automatic unlock();
    acc_start(1'b0, 1'b1, 3'd1, 16'h0); acc_end();
    acc_start(1'b0, 1'b1, 3'd1, 16'h0); acc_end();
    acc_start(1'b1, 1'b0, 3'd2, 16'h0003); acc_end();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", host_rdata, 16'h0);
    chk("R1 timing", {d0_rd_tim, d0_wr_tim, d1_rd_tim, d1_wr_tim}, 32'h0);
    chk("R1 fields", {addr_setup, rdy_delay}, 4'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [24:0] v;
      v = VEC[i];
      acc_start(v[24], v[23], v[22:20], v[15:0]);
      acc_end();
      if (!v[24]) chk($sformatf("R%0d vec %0d", v[19:16], i), host_rdata, v[15:0]);
    end

    repeat (2) @(negedge clk);
    // R9 drive 0 from set A, drive 1 from set B; R12 locked writes had no effect
    chk("R9 d0", {d0_rd_tim, d0_wr_tim}, 16'h2132);
    chk("R9 d1", {d1_rd_tim, d1_wr_tim}, 16'h4354);
    chk("R10 fields", {addr_setup, rdy_delay}, 4'b1010);

    // R2 forwarding of a locked write
    acc_start(1'b1, 1'b1, 3'd4, 16'h1234);
    #1;
    chk("R2 drv_wr", {drv_wr, drv_rd, drv_word}, 3'b101);
    chk("R2 drv bus", {13'b0, drv_addr, drv_wdata}, {13'b0, 3'd4, 16'h1234});
    acc_end();

    // R5 no drive strobes while open
    unlock();
    acc_start(1'b0, 1'b1, 3'd3, 16'h0);
    #1;
    chk("R5 read", {drv_rd, drv_wr}, 2'b00);
    acc_end();
    chk("R5 cfg data", host_rdata, 16'h0085);
    acc_start(1'b1, 1'b0, 3'd3, 16'h0000);
    #1;
    chk("R5 write", {drv_rd, drv_wr}, 2'b00);
    acc_end();
    repeat (2) @(negedge clk);
    chk("R9 d1 back to A", {d1_rd_tim, d1_wr_tim}, 16'h2132);

    // R7 strap at 33 MHz
    strap_clk25 = 1'b0;
    acc_start(1'b0, 1'b0, 3'd5, 16'h0); acc_end();
    chk("R7 strap 0", host_rdata, 16'h0000);

    // R1 reset while open closes the window and clears registers
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R1 timing after reset", {d0_rd_tim, d0_wr_tim, d1_rd_tim, d1_wr_tim}, 32'h0);
    acc_start(1'b0, 1'b1, 3'd3, 16'h0); acc_end();
    chk("R1 window closed", host_rdata, 16'hA503);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule